// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one machine cycle at a time on an external bus whose low address byte and 8-bit data share the same pins. A client hands it a request, which carries a cycle kind, a 16-bit address and write data. The controller then sequences the cycle through its clock states. In the first state it drives the whole address and pulses the latch strobe, so external logic can capture the low byte. In the later states it drives or samples data under an active-low read or write strobe. Alongside each cycle it presents a memory/I-O select and a two-bit status code.

A slow device holds the ready input low to stretch a cycle by whole clock states. A second bus master may request the bus at any time. The controller grants that request only between machine cycles. While the request is granted, the controller withdraws its output enables and accepts no new request.

Top module: `abus_cycle_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, rd_n and wr_n are 1, ale, ad_oe, hold_ack and done are 0, bus_oe is 1, stat is 00, io_sel is 0, and req_ready equals !hold_req.
- R2: A request accepted at a clock edge (req_valid and req_ready both 1) makes the next cycle the first state. In that state ale is 1, ad_oe is 1, ad_out carries address bits 7..0 and addr_hi carries address bits 15..8. ale is high in no other cycle.
- R3: The kind code maps to {stat, io_sel} as follows: 1 opcode fetch = 11/0, 2 memory read = 10/0, 3 memory write = 01/0, 4 I/O read = 10/1, 5 I/O write = 01/1. Code 0 and the unused codes 6 and 7 run a halt cycle = 00/0. These values are held from the first state until the next request is accepted.
- R4: For the read kinds (1, 2, 4), rd_n is low from the second state through the third state. ad_in is captured at the clock edge that ends the third state. done is 1 for exactly the following cycle, and in that cycle rdata shows the captured byte. rdata keeps that byte until the next read completes.
- R5: For the write kinds (3, 5), wr_n is low from the second state through the third state. During that span ad_oe is 1 and ad_out carries the write data. rd_n and wr_n are never low together.
- R6: ready_in is sampled at the edge that ends the second state and at the edge that ends each wait state. Each low sample adds one wait state before the third state, so a strobe stays low for 2 + N cycles when N low samples occur.
- R7: A halt cycle drives neither strobe. ad_oe is 1 only in its first state, and done still pulses after its third state.
- R8: hold_req is acted on only when idle or at the edge that ends a third state. hold_ack then rises in the next cycle, with bus_oe and ad_oe at 0 and ale at 0 for as long as hold_ack is 1.
- R9: When hold_req is sampled low while hold_ack is 1, hold_ack falls and bus_oe returns to 1 in the next cycle. That cycle is idle.
- R10: req_ready is 1 only when the controller is idle and hold_req is 0. A req_valid pulse seen while req_ready is 0 starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted at this edge if valid |
| done | output | 1 | One-cycle pulse after a cycle completes |
| rdata | output | 8 | Last byte read |
| ready_in | input | 1 | Device ready; low inserts wait states |
| hold_req | input | 1 | Other master asks for the bus |
| hold_ack | output | 1 | Bus granted to the other master |
| bus_oe | output | 1 | Enable for addr_hi, io_sel, stat and strobes |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared low-address/data byte, driven value |
| ad_oe | output | 1 | Enable for ad_out |
| ad_in | input | 8 | Shared low-address/data byte, received value |
| ale | output | 1 | Address latch strobe |
| io_sel | output | 1 | 1 = I/O access, 0 = memory |
| stat | output | 2 | Status code of the cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench goes after zero, one and several wait states. A design that sampled ready one state late, or sampled it only once, would give the wrong strobe length. It raises the hold request in the middle of a stretched read. A controller that granted it at once would float the bus with a strobe still low, or lose the done pulse. It also keeps a request waiting behind a held bus, which exposes a design that starts a cycle while it has no ownership of the bus. Unused kind codes and back-to-back kinds with different status are included, to catch status that is decoded wrongly or goes stale.

// File: rtl/abus_cycle_ctrl.sv
module abus_cycle_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  input  logic                     ready_in,
  input  logic                     hold_req,
  output logic                     hold_ack,
  output logic                     bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     io_sel,
  output logic [1:0]               stat,
  output logic                     rd_n,
  output logic                     wr_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_TW = 3'd3, S_T3 = 3'd4, S_HOLD = 3'd5
  } phase_t;

  phase_t            state_q;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic k_read, k_write, k_io, k_fetch, in_data;

  assign k_fetch = (kind_q == 3'd1);
  assign k_read  = (kind_q == 3'd1) || (kind_q == 3'd2) || (kind_q == 3'd4);
  assign k_write = (kind_q == 3'd3) || (kind_q == 3'd5);
  assign k_io    = (kind_q == 3'd4) || (kind_q == 3'd5);
  assign in_data = (state_q == S_T2) || (state_q == S_TW) || (state_q == S_T3);

  assign req_ready = (state_q == S_IDLE) && !hold_req;
  assign hold_ack  = (state_q == S_HOLD);
  assign bus_oe    = !hold_ack;
  assign ale       = (state_q == S_T1);
  assign ad_oe     = ale || (in_data && k_write);
  assign ad_out    = ale ? addr_q[DATA_W-1:0] : wdata_q;
  assign addr_hi   = addr_q[ADDR_W-1 -: HI_W];
  assign io_sel    = k_io;
  assign stat      = k_write ? 2'b01 : k_fetch ? 2'b11 : k_read ? 2'b10 : 2'b00;
  assign rd_n      = !(in_data && k_read);
  assign wr_n      = !(in_data && k_write);
  assign done      = done_q;
  assign rdata     = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= (state_q == S_T3);
      case (state_q)
        S_IDLE: begin
          if (hold_req) state_q <= S_HOLD;
          else if (req_valid) begin
            state_q <= S_T1;
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        S_T1:    state_q <= S_T2;
        S_T2,
        S_TW:    state_q <= ready_in ? S_T3 : S_TW;
        S_T3: begin
          if (k_read) rdata_q <= ad_in;
          state_q <= hold_req ? S_HOLD : S_IDLE;
        end
        S_HOLD:  if (!hold_req) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abus_cycle_ctrl_chk.sv
module abus_cycle_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       bus_oe,
  input logic       ad_oe,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ready_in,
  input logic       req_ready,
  input logic [2:0] state_q
);
  localparam logic [2:0] P_T2 = 3'd2;
  localparam logic [2:0] P_TW = 3'd3;

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_drives_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);
  assert_read_after_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(ale));
  assert_write_after_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ale));
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_wait_inserted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == P_T2 || state_q == P_TW) && !ready_in) |=> (state_q == P_TW));
  assert_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_oe && !ad_oe && !ale && rd_n && wr_n));
  assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req));
  assert_release_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> !$past(hold_req));
  assert_no_accept_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!hold_req && !hold_ack));
endmodule

bind abus_cycle_ctrl abus_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .bus_oe(bus_oe), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ready_in(ready_in), .req_ready(req_ready), .state_q(state_q)
);

// File: tb/abus_cycle_ctrl_bench.sv
module abus_cycle_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, ad_in = 0;
  logic ready_in = 1, hold_req = 0;
  logic req_ready, done, hold_ack, bus_oe, ad_oe, ale, io_sel, rd_n, wr_n;
  logic [7:0] rdata, addr_hi, ad_out;
  logic [1:0] stat;

  int checks = 0, fails = 0, waits_left = 0;

  always #10 clk = ~clk;

  abus_cycle_ctrl u_abus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rdata(rdata), .ready_in(ready_in), .hold_req(hold_req), .hold_ack(hold_ack),
    .bus_oe(bus_oe), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .io_sel(io_sel), .stat(stat), .rd_n(rd_n), .wr_n(wr_n));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 first, 2 second, 3 wait, 4 third, 5 released
  int m_ph = 0, m_kind = 0;
  logic [15:0] m_addr = 0;
  logic [7:0] m_wd = 0, m_rd = 0;
  bit m_done = 0;

  function automatic bit is_rd(int k); return k == 1 || k == 2 || k == 4; endfunction
  function automatic bit is_wr(int k); return k == 3 || k == 5; endfunction
  function automatic logic [2:0] sio(int k);
    case (k)
      1: return 3'b110; 2: return 3'b100; 3: return 3'b010;
      4: return 3'b101; 5: return 3'b011; default: return 3'b000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_kind = 0; m_addr = 0; m_wd = 0; m_rd = 0; m_done = 0;
    end else begin
      m_done = (m_ph == 4);
      case (m_ph)
        0: if (hold_req) m_ph = 5;
           else if (req_valid) begin
             m_ph = 1; m_kind = req_kind; m_addr = req_addr; m_wd = req_wdata;
           end
        1: m_ph = 2;
        2, 3: m_ph = ready_in ? 4 : 3;
        4: begin
             if (is_rd(m_kind)) m_rd = ad_in;
             m_ph = hold_req ? 5 : 0;
           end
        default: if (!hold_req) m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit dat, e_oe;
      dat = (m_ph >= 2 && m_ph <= 4);
      e_oe = (m_ph == 1) || (dat && is_wr(m_kind));
      chk(ale == (m_ph == 1), "R2 ale", ale, m_ph == 1);
      chk(ad_oe == e_oe, "R2/R5 ad_oe", ad_oe, e_oe);
      if (m_ph == 1) chk(ad_out == m_addr[7:0], "R2 low address", ad_out, m_addr[7:0]);
      if (dat && is_wr(m_kind)) chk(ad_out == m_wd, "R5 write data", ad_out, m_wd);
      chk(addr_hi == m_addr[15:8], "R2 high address", addr_hi, m_addr[15:8]);
      chk({stat, io_sel} == sio(m_kind), "R3 status", {stat, io_sel}, sio(m_kind));
      chk(rd_n == !(dat && is_rd(m_kind)), "R4 rd_n", rd_n, !(dat && is_rd(m_kind)));
      chk(wr_n == !(dat && is_wr(m_kind)), "R5 wr_n", wr_n, !(dat && is_wr(m_kind)));
      chk(done == m_done, "R4 done", done, m_done);
      chk(rdata == m_rd, "R4 rdata", rdata, m_rd);
      chk(hold_ack == (m_ph == 5), "R8 hold_ack", hold_ack, m_ph == 5);
      chk(bus_oe == (m_ph != 5), "R9 bus_oe", bus_oe, m_ph != 5);
      chk(req_ready == (m_ph == 0 && !hold_req), "R10 req_ready", req_ready, m_ph == 0 && !hold_req);
    end
  end

  // slow device: pulls ready low for waits_left samples once a strobe appears
  always @(negedge clk) begin
    if ((!rd_n || !wr_n) && waits_left > 0) begin
      ready_in = 0; waits_left--;
    end else ready_in = 1;
  end

  task automatic run_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rv, input int nw);
    int strobes = 0, guard = 0;
    int exp_s;
    waits_left = nw;
    ad_in = rv;
    @(negedge clk); #2;
    req_valid = 1; req_kind = kind[2:0]; req_addr = a; req_wdata = wd;
    while (!req_ready && guard < 200) begin @(negedge clk); #2; guard++; end
    @(negedge clk); #2;
    req_valid = 0; req_kind = 3'd7; req_addr = 16'hDEAD; req_wdata = 8'h00;
    guard = 0;
    while (!done && guard < 200) begin
      if (!rd_n || !wr_n) strobes++;
      @(negedge clk); guard++;
    end
    exp_s = (is_rd(kind) || is_wr(kind)) ? 2 + nw : 0;
    if (exp_s == 0) chk(strobes == 0, "R7 halt strobes", strobes, 0);
    else chk(strobes == exp_s, "R6 strobe length", strobes, exp_s);
    if (is_rd(kind)) chk(rdata == rv, "R4 read byte", rdata, rv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && !ale && !hold_ack && bus_oe && !ad_oe && !done, "R1 in reset", {rd_n, wr_n, ale}, 3'b110);
    #2 rst_n = 1;
    @(negedge clk);
    chk(stat == 2'b00 && !io_sel && req_ready && rd_n && wr_n, "R1 after reset", {stat, io_sel, req_ready}, 4'b0001);

    run_cycle(1, 16'h2501, 8'h00, 8'h3E, 0);
    run_cycle(2, 16'h12F0, 8'h00, 8'h9F, 2);
    run_cycle(3, 16'hA55A, 8'hC3, 8'h00, 0);
    run_cycle(4, 16'h0080, 8'h00, 8'h17, 1);
    run_cycle(5, 16'hFF01, 8'h5A, 8'h00, 3);
    run_cycle(0, 16'h7777, 8'h00, 8'h00, 2);   // R7
    run_cycle(7, 16'h0102, 8'h00, 8'h00, 0);   // R3 unused code
    chk(rdata == 8'h17, "R4 rdata kept", rdata, 8'h17);

    // R8 grant from idle, R9 release
    @(negedge clk); #2 hold_req = 1;
    @(negedge clk);
    chk(hold_ack && !bus_oe, "R8 grant idle", hold_ack, 1);
    repeat (3) @(negedge clk);
    #2 hold_req = 0;
    @(negedge clk);
    chk(!hold_ack && bus_oe && req_ready, "R9 release", hold_ack, 0);

    // R8 hold raised mid-cycle waits for the cycle end
    fork
      run_cycle(2, 16'h3344, 8'h00, 8'hB6, 3);
      begin repeat (4) @(negedge clk); #2 hold_req = 1; end
    join
    chk(hold_ack, "R8 grant after cycle", hold_ack, 1);
    chk(rdata == 8'hB6, "R8 read kept through grant", rdata, 8'hB6);
    repeat (2) @(negedge clk);
    #2 hold_req = 0;
    @(negedge clk);
    chk(!hold_ack && bus_oe, "R9 release after mid grant", hold_ack, 0);

    // R10 request waits behind a held bus
    @(negedge clk); #2 hold_req = 1;
    fork
      run_cycle(3, 16'h4455, 8'h81, 8'h00, 1);
      begin
        repeat (5) @(negedge clk);
        chk(!ale && rd_n && wr_n && hold_ack, "R10 no cycle while held", ale, 0);
        #2 hold_req = 0;
      end
    join
    run_cycle(1, 16'h0000, 8'h00, 8'hFF, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule